// File: doc/BRIEF.md
# Conditional ALU with Status Flags

This block is the execute-stage slice of a small integer datapath. It performs add, subtract, compare and the three bitwise logic operations on two operands. It keeps four condition flags in a status register: negative, zero, carry and signed overflow. Every operation carries a 4-bit condition field. The field is tested against the flags that are already stored. If the test fails, the operation has no effect: nothing is written back and the flags are left as they are.

The decoder presents one operation per cycle and marks it with `issue`. The result and its write enable are combinational, so the register file can capture the result at the same clock edge at which the flags update. A per-operation update bit chooses whether a passing operation writes the flags. A compare updates the flags and never the destination. The same stored flags feed both signed tests (less, greater) and unsigned tests (below, above). These two families give different answers for operands whose top bit differs.

Top module: `cond_alu_unit`

## Requirements
- R1: The operation encodings on `op` are 000 add, 001 subtract, 010 compare, 011 AND, 100 OR and 101 XOR. Add returns `opa + opb` modulo 2^DATA_W. Subtract returns `opa - opb` modulo 2^DATA_W. The logic operations return the bitwise result.
- R2: `res_we` is high exactly when `issue` is high, the condition passes and the operation is add, subtract, AND, OR or XOR. A compare never raises `res_we`.
- R3: The flags change at a rising clock edge only if, in that cycle, `issue`, `upd` and the condition pass are all high and the operation is valid. Otherwise all four flags hold their value.
- R4: After add, subtract or compare, `flags[3]` (N) is the top result bit, `flags[2]` (Z) shows an all-zero result, `flags[1]` (C) is the carry out, and `flags[0]` (V) is signed overflow. For subtract and compare, C=1 means no borrow, so C=1 exactly when `opa >= opb` unsigned.
- R5: AND, OR and XOR update N and Z from their result and leave C and V unchanged.
- R6: Conditions 0000 to 1001 test the stored flags as follows: Z, !Z, C, !C, N, !N, V, !V, unsigned above (C & !Z), and unsigned below-or-same (!C | Z).
- R7: The signed conditions are 1010 greater-or-equal (N==V), 1011 less (N!=V), 1100 greater (!Z & N==V) and 1101 less-or-equal (Z | N!=V).
- R8: Condition 1110 always passes. Condition 1111 never passes, so an operation with 1111 writes neither the result nor the flags.
- R9: Op codes 110 and 111 are reserved. They return a zero result, never raise `res_we` and never change the flags.
- R10: Reset clears all four flags. `exec_ok` equals `issue` AND the condition pass, so it is low whenever `issue` is low.
- R11: Signed and unsigned orderings disagree when the operands' top bits differ. With DATA_W=8, after comparing 8'hFF with 8'h00, condition 1000 (above) passes and condition 1011 (less) also passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | An operation is present this cycle |
| op | input | 3 | Operation select |
| upd | input | 1 | Write the flags if the operation executes |
| cond | input | 4 | Condition field |
| opa | input | DATA_W | First operand |
| opb | input | DATA_W | Second operand |
| result | output | DATA_W | Operation result |
| res_we | output | 1 | Result write enable |
| flags | output | 4 | Stored flags {N,Z,C,V} |
| exec_ok | output | 1 | Operation permitted this cycle |

## Verification
The bench builds the unit with DATA_W=8 and the ripple-carry adder variant (ADDER_IMPL=1). At 8 bits, random operands hit the cases that matter often: 7F/80 signed overflow, FF+01 wrapping to zero, and top-bit-mismatch compares where the signed and unsigned conditions split. The ripple variant checks the per-bit carry chain and the carry-based overflow rule. The behavioural adder does not use either of these.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'b000,
      OP_SUB = 3'b001,
      OP_CMP = 3'b010,
      OP_AND = 3'b011,
      OP_ORR = 3'b100,
      OP_XOR = 3'b101,
      OP_RS6 = 3'b110,
      OP_RS7 = 3'b111
   } cxu_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } cxu_flags_t;

   localparam logic [3:0] CC_ZS = 4'b0000;
   localparam logic [3:0] CC_ZC = 4'b0001;
   localparam logic [3:0] CC_CS = 4'b0010;
   localparam logic [3:0] CC_CC = 4'b0011;
   localparam logic [3:0] CC_NS = 4'b0100;
   localparam logic [3:0] CC_NC = 4'b0101;
   localparam logic [3:0] CC_VS = 4'b0110;
   localparam logic [3:0] CC_VC = 4'b0111;
   localparam logic [3:0] CC_UA = 4'b1000;
   localparam logic [3:0] CC_UBE = 4'b1001;
   localparam logic [3:0] CC_SGE = 4'b1010;
   localparam logic [3:0] CC_SLT = 4'b1011;
   localparam logic [3:0] CC_SGT = 4'b1100;
   localparam logic [3:0] CC_SLE = 4'b1101;
   localparam logic [3:0] CC_ANY = 4'b1110;
   localparam logic [3:0] CC_NONE = 4'b1111;

endpackage

// File: rtl/cxu_adder.sv
module cxu_adder #(
   parameter int DATA_W     = 32,
   parameter int ADDER_IMPL = 0
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              ovf
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cxu_adder: DATA_W must be at least 2");
      end
      if (ADDER_IMPL != 0 && ADDER_IMPL != 1) begin : g_bad_impl
         $error("cxu_adder: ADDER_IMPL must be 0 or 1");
      end

      if (ADDER_IMPL == 1) begin : g_ripple
         logic [DATA_W:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
         assign cout = cy[DATA_W];
         assign ovf  = cy[DATA_W] ^ cy[MSB];
      end else begin : g_behav
         logic [DATA_W:0] wide;
         assign wide = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
         assign sum  = wide[MSB:0];
         assign cout = wide[DATA_W];
         assign ovf  = (a[MSB] == b[MSB]) && (wide[MSB] != a[MSB]);
      end
   endgenerate
endmodule

// File: rtl/cxu_cond_eval.sv
module cxu_cond_eval
   import cxu_pkg::*;
(
   input  cxu_flags_t fl,
   input  logic [3:0] cond,
   output logic       pass
);
   logic sgn_ge;
   assign sgn_ge = (fl.n == fl.v);

   always_comb begin
      unique case (cond)
         CC_ZS:   pass = fl.z;
         CC_ZC:   pass = !fl.z;
         CC_CS:   pass = fl.c;
         CC_CC:   pass = !fl.c;
         CC_NS:   pass = fl.n;
         CC_NC:   pass = !fl.n;
         CC_VS:   pass = fl.v;
         CC_VC:   pass = !fl.v;
         CC_UA:   pass = fl.c && !fl.z;
         CC_UBE:  pass = !fl.c || fl.z;
         CC_SGE:  pass = sgn_ge;
         CC_SLT:  pass = !sgn_ge;
         CC_SGT:  pass = !fl.z && sgn_ge;
         CC_SLE:  pass = fl.z || !sgn_ge;
         CC_ANY:  pass = 1'b1;
         default: pass = 1'b0;
      endcase
   end
endmodule

// File: rtl/cxu_flag_reg.sv
module cxu_flag_reg
   import cxu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_nz,
   input  logic       we_cv,
   input  cxu_flags_t nxt,
   output cxu_flags_t cur
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= '0;
      end else begin
         if (we_nz) begin
            cur.n <= nxt.n;
            cur.z <= nxt.z;
         end
         if (we_cv) begin
            cur.c <= nxt.c;
            cur.v <= nxt.v;
         end
      end
   end
endmodule

// File: rtl/cond_alu_unit.sv
module cond_alu_unit
   import cxu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDER_IMPL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [2:0]        op,
   input  logic              upd,
   input  logic [3:0]        cond,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   output logic [DATA_W-1:0] result,
   output logic              res_we,
   output logic [3:0]        flags,
   output logic              exec_ok
);
   localparam int MSB = DATA_W - 1;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cond_alu_unit: DATA_W must be at least 2");
      end
   endgenerate

   cxu_op_e op_d;
   assign op_d = cxu_op_e'(op);

   logic is_sub, is_arith, is_logic, writes_res;
   always_comb begin
      is_sub     = (op_d == OP_SUB) || (op_d == OP_CMP);
      is_arith   = (op_d == OP_ADD) || is_sub;
      is_logic   = (op_d == OP_AND) || (op_d == OP_ORR) || (op_d == OP_XOR);
      writes_res = is_logic || (op_d == OP_ADD) || (op_d == OP_SUB);
   end

   // Adder path: subtraction is a + ~b + 1, carry out means no borrow
   logic [DATA_W-1:0] add_b, add_sum;
   logic              add_co, add_ov;
   assign add_b = is_sub ? ~opb : opb;

   cxu_adder #(.DATA_W(DATA_W), .ADDER_IMPL(ADDER_IMPL)) u_add (
      .a    (opa),
      .b    (add_b),
      .cin  (is_sub),
      .sum  (add_sum),
      .cout (add_co),
      .ovf  (add_ov)
   );

   logic [DATA_W-1:0] lg_res;
   always_comb begin
      unique case (op_d)
         OP_AND:  lg_res = opa & opb;
         OP_ORR:  lg_res = opa | opb;
         OP_XOR:  lg_res = opa ^ opb;
         default: lg_res = '0;
      endcase
   end

   assign result = is_arith ? add_sum : lg_res;

   // Condition test against the stored flags
   cxu_flags_t fl_q, fl_d;
   logic       cpass;

   cxu_cond_eval u_cond (
      .fl   (fl_q),
      .cond (cond),
      .pass (cpass)
   );

   assign exec_ok = issue && cpass;
   assign res_we  = exec_ok && writes_res;

   logic we_nz, we_cv;
   assign we_nz = exec_ok && upd && (is_arith || is_logic);
   assign we_cv = we_nz && is_arith;

   always_comb begin
      fl_d.n = result[MSB];
      fl_d.z = (result == '0);
      fl_d.c = add_co;
      fl_d.v = add_ov;
   end

   cxu_flag_reg u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .we_nz (we_nz),
      .we_cv (we_cv),
      .nxt   (fl_d),
      .cur   (fl_q)
   );

   assign flags = fl_q;

   // Assertions guarding the gating and condition logic
   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'b010) |-> !res_we); // R2

   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue || !upd || !exec_ok || op[2:1] == 2'b11) |=> $stable(flags)); // R3

   AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_ok && upd && (op == 3'b011 || op == 3'b100 || op == 3'b101))
      |=> (flags[1:0] == $past(flags[1:0]))); // R5

   AST_SIGNED_GE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cond == 4'b1010) |-> (exec_ok == (flags[3] == flags[0]))); // R7

   AST_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && cond == 4'b1110) |-> exec_ok); // R8

   AST_NEVER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
      (cond == 4'b1111) |-> (!exec_ok && !res_we)); // R8

   AST_RESERVED_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (op[2:1] == 2'b11) |-> (!res_we && result == '0)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |-> (!exec_ok && !res_we)); // R10

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_ok && upd && op[2:1] != 2'b11) |=> (flags[2] == ($past(result) == '0))); // R4
endmodule

// File: tb/tb_cond_alu_unit.sv
module tb_cond_alu_unit;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         issue = 1'b0;
   logic [2:0]   op = 3'b0;
   logic         upd = 1'b0;
   logic [3:0]   cond = 4'b0;
   logic [W-1:0] opa = '0, opb = '0;
   logic [W-1:0] result;
   logic         res_we, exec_ok;
   logic [3:0]   flags;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference flag state
   bit mN = 0, mZ = 0, mC = 0, mV = 0;
   string fl_tag = "R10";

   always #5 clk = ~clk;

   cond_alu_unit #(.DATA_W(W), .ADDER_IMPL(1)) dut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .upd(upd),
      .cond(cond), .opa(opa), .opb(opb), .result(result),
      .res_we(res_we), .flags(flags), .exec_ok(exec_ok)
   );

   task automatic chk(input string tag, input string what,
                      input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
      end
   endtask

   function automatic bit cond_ok(input logic [3:0] c);
      case (c)
         0:  return mZ;
         1:  return !mZ;
         2:  return mC;
         3:  return !mC;
         4:  return mN;
         5:  return !mN;
         6:  return mV;
         7:  return !mV;
         8:  return mC && !mZ;
         9:  return !mC || mZ;
         10: return mN == mV;
         11: return mN != mV;
         12: return !mZ && (mN == mV);
         13: return mZ || (mN != mV);
         14: return 1;
         default: return 0;
      endcase
   endfunction

   function automatic string cond_tag(input logic [3:0] c);
      if (c < 10) return "R6";
      if (c < 14) return "R7";
      return "R8";
   endfunction

   task automatic step(input bit iss, input int o, input bit u, input int c,
                       input int a, input int b, input string xtag);
      int  ua, ub, s, er, ec, ev;
      bit  pass, ok, wr, arith, logic_op;
      @(negedge clk);
      issue = iss; op = 3'(o); upd = u; cond = 4'(c);
      opa = W'(a); opb = W'(b);
      ua = a & 255; ub = b & 255;
      arith = (o <= 2); logic_op = (o >= 3 && o <= 5);
      ec = 0; ev = 0; er = 0;
      if (o == 0) begin
         s = ua + ub; er = s & 255; ec = (s >> 8) & 1;
         ev = int'(((ua >> 7) == (ub >> 7)) && (((er >> 7) & 1) != (ua >> 7)));
      end else if (o == 1 || o == 2) begin
         er = (ua - ub) & 255; ec = int'(ua >= ub);
         ev = int'(((ua >> 7) != (ub >> 7)) && (((er >> 7) & 1) != (ua >> 7)));
      end else if (o == 3) er = ua & ub;
      else if (o == 4) er = ua | ub;
      else if (o == 5) er = ua ^ ub;
      pass = cond_ok(4'(c));
      ok   = iss && pass;
      wr   = ok && (o == 0 || o == 1 || logic_op);
      #2;
      chk(fl_tag, "flags", int'(flags), int'({mN, mZ, mC, mV}));
      chk(xtag != "" ? xtag : (iss ? cond_tag(4'(c)) : "R10"), "exec_ok",
          int'(exec_ok), int'(ok));
      chk(o >= 6 ? "R9" : "R2", "res_we", int'(res_we), int'(wr));
      chk(o >= 6 ? "R9" : "R1", "result", int'(result), er);
      @(posedge clk);
      #1;
      if (ok && u && (arith || logic_op)) begin
         mN = er[7]; mZ = (er == 0);
         if (arith) begin mC = ec[0]; mV = ev[0]; fl_tag = "R4"; end
         else fl_tag = "R5";
      end else fl_tag = "R3";
   endtask

   function automatic int pick_val();
      int r = $urandom % 8;
      case (r)
         0: return 8'h00;
         1: return 8'h7F;
         2: return 8'h80;
         3: return 8'hFF;
         4: return 8'h01;
         default: return $urandom % 256;
      endcase
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R10", "flags after reset", int'(flags), 0);
      chk("R10", "exec_ok idle", int'(exec_ok), 0);
      chk("R10", "res_we idle", int'(res_we), 0);
      @(negedge clk); rst_n = 1'b1;

      // R4: add overflow 7F+01, carry FF+01 to zero
      step(1, 0, 1, 14, 8'h7F, 8'h01, "");
      step(1, 0, 1, 14, 8'hFF, 8'h01, "");
      step(1, 1, 1, 14, 8'h80, 8'h01, "");
      step(1, 1, 1, 14, 8'h05, 8'h07, "");
      // R5: logic keeps C and V from the subtract above
      step(1, 3, 1, 14, 8'hF0, 8'h0F, "");
      step(1, 5, 1, 14, 8'hAA, 8'h55, "");
      // R3: update bit clear holds flags
      step(1, 0, 0, 14, 8'h00, 8'h00, "");
      // R2: compare does not write
      step(1, 2, 1, 14, 8'h10, 8'h10, "");
      step(1, 0, 1, 0, 8'h01, 8'h02, "R6");
      // R11: FF vs 00, above and less both pass
      step(1, 2, 1, 14, 8'hFF, 8'h00, "");
      step(1, 0, 0, 8, 8'h01, 8'h01, "R11");
      step(1, 0, 0, 11, 8'h01, 8'h01, "R11");
      step(1, 0, 0, 10, 8'h01, 8'h01, "R7");
      // R8: never-execute blocks write and flags
      step(1, 1, 1, 15, 8'h00, 8'h01, "R8");
      // R9: reserved ops
      step(1, 6, 1, 14, 8'h12, 8'h34, "");
      step(1, 7, 1, 14, 8'h56, 8'h78, "");
      // R10: idle cycle
      step(0, 0, 1, 14, 8'h01, 8'h01, "R10");

      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 8) != 0, $urandom % 8, $urandom % 4 != 0,
              ($urandom % 3 == 0) ? 14 : $urandom % 16,
              pick_val(), pick_val(), "");
      end
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired got=0 exp=1");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule